// File: doc/BRIEF.md
# Filter Control Registers and Start Controller

This block is the configuration front end of a two-stage decimating filter. A host writes 16-bit words through a parallel port made of a 2-bit register select, an active-low chip select and an active-low write strobe. A write takes effect when the strobe returns high. The block holds the settings for the FIR stage and the decimator stage, and presents every field as a separate output.

Coefficients are 20 bits wide and arrive as two 16-bit writes to one address. Once the pair is complete, the block emits a one-cycle coefficient write with an address that advances by one after each coefficient. The coefficient memory and both filter datapaths sit outside this block.

A start controller arms the filter. One start input is asynchronous and passes through a two-flop synchronizer. The other start input is synchronous. A falling edge on either input latches a run flag, which stays set until reset. The run flag also gates the rate divider and the capture of input samples. A falling edge on the asynchronous input also produces an active-low cascade pulse, one clock wide, which can drive the synchronous start of a second device.

Top module: `filt_ctrl_start`

## Requirements
- R1: A write commits at the first rising clock edge that sees `wr_n` high after a clock edge that saw it low, using the `cs_n`, `addr` and `wdata` values sampled while `wr_n` was low. If `cs_n` was high during the strobe, no register changes.
- R2: Select 0 is the FIR configuration register. Bits 8:0 hold the tap count, bits 12:9 the FIR rate, bit 13 even symmetry, bit 14 FIR bypass and bit 15 zero-preadder.
- R3: Select 2 is decimator register 1. Bits 9:0 hold the decimator rate, bit 10 decimator bypass, bit 11 clear-accumulate and bit 12 FIR disable.
- R4: Select 3 is decimator register 2. Bits 2:0 hold the stage count and bits 8:3 the growth value.
- R5: Select 1 takes coefficients in pairs. The first write supplies coefficient bits 19:4. The second write supplies bits 3:0 from its low nibble, and its other bits are ignored. On the edge after the second write commits, `coef_we` is high for exactly one cycle with the assembled `coef_data`.
- R6: Coefficient addresses start at 0 and go up by one for each completed coefficient.
- R7: Reset clears FIR bypass, stage count and decimator rate, and sets FIR disable. It also returns the coefficient address to 0 and the pairing to first-half. Tap count, FIR rate, symmetry, zero-preadder, clear-accumulate, decimator bypass and growth keep their values.
- R8: A write to select 2 with bit 12 set returns the coefficient address to 0. It also discards any pending first half, so the next select-1 write counts as a first half.
- R9: The asynchronous start is registered twice. After the first edge that samples it low, `casc_n` goes low after the second edge for exactly one cycle. `run` rises after the third edge. The synchronous start never drives `casc_n`.
- R10: A falling edge on `sstart_n`, as seen by consecutive rising edges, sets `run` one edge after the edge that first samples it low.
- R11: `run` is low from reset until a start, and stays high once set until reset.
- R12: A start clears FIR disable on the same edge that sets `run`. This takes precedence over a simultaneous disable write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| wr_n | input | 1 | Active-low write strobe; write commits on its return high |
| addr | input | 2 | Register select |
| wdata | input | 16 | Write data |
| astart_n | input | 1 | Asynchronous start, acts on a falling edge |
| sstart_n | input | 1 | Synchronous start, acts on a falling edge |
| casc_n | output | 1 | One-cycle active-low cascade start pulse |
| run | output | 1 | Run flag; enables the rate divider and sample capture |
| fir_zero_pre | output | 1 | Zero one preadder input |
| fir_bypass | output | 1 | FIR bypass |
| fir_even_sym | output | 1 | Even symmetry (add) when high |
| fir_dec_rate | output | 4 | FIR decimation minus one |
| fir_taps | output | 9 | Tap count minus one |
| fir_disable | output | 1 | FIR disable |
| fir_clr_acc | output | 1 | Clear accumulator feedback |
| dec_bypass | output | 1 | Decimator bypass |
| dec_rate | output | 10 | Decimator decimation minus one |
| dec_growth | output | 6 | Growth shift value |
| dec_stages | output | 3 | Decimator stage count |
| coef_we | output | 1 | Coefficient write pulse |
| coef_addr | output | 8 | Coefficient write address |
| coef_data | output | 20 | Assembled coefficient |

## Verification
Register fields change on the edge that commits a write, so the bench samples them at the falling edge right after that commit. The coefficient pulse falls in the same window, and a monitor that pops a queue of expected address and value pairs catches it there. For the asynchronous start, the bench samples at the falling edge after each of three rising edges, expecting no effect, then the cascade pulse, then `run` with disable cleared. For the synchronous start, it expects nothing after the first edge and `run` after the second. Timing is always counted from the falling edge where the bench drives the input.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int BUS_W  = 16;
  localparam int SEL_W  = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_FIRCFG = 2'd0,
    SEL_COEF   = 2'd1,
    SEL_DEC1   = 2'd2,
    SEL_DEC2   = 2'd3
  } reg_sel_e;

  // FIR configuration word layout
  localparam int TAPS_LSB = 0;
  localparam int TAPS_W   = 9;
  localparam int FDEC_LSB = 9;
  localparam int FDEC_W   = 4;
  localparam int FSYM_BIT = 13;
  localparam int FBYP_BIT = 14;
  localparam int FZP_BIT  = 15;

  // decimator word 1 layout
  localparam int HRATE_LSB = 0;
  localparam int HRATE_W   = 10;
  localparam int HBYP_BIT  = 10;
  localparam int CLA_BIT   = 11;
  localparam int DIS_BIT   = 12;

  // decimator word 2 layout
  localparam int STG_LSB = 0;
  localparam int STG_W   = 3;
  localparam int GRW_LSB = 3;
  localparam int GRW_W   = 6;
endpackage

// File: rtl/fcs_bus.sv
module fcs_bus
  import fcs_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cs_n,
  input  logic             wr_n,
  input  logic [SEL_W-1:0] addr,
  input  logic [DW-1:0]    wdata,
  output logic             commit,
  output reg_sel_e         c_sel,
  output logic [DW-1:0]    c_data
);
  logic             wr_q;
  logic             cs_lat_n;
  logic [SEL_W-1:0] addr_lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q     <= 1'b1;
      cs_lat_n <= 1'b1;
    end else begin
      wr_q <= wr_n;
      if (!wr_n) cs_lat_n <= cs_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!wr_n) begin
      addr_lat <= addr;
      c_data   <= wdata;
    end
  end

  assign commit = !wr_q && wr_n && !cs_lat_n;
  assign c_sel  = reg_sel_e'(addr_lat);

  // a strobe can commit at most once
  assert_single_commit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !commit);
endmodule

// File: rtl/fcs_regs.sv
module fcs_regs
  import fcs_pkg::*;
#(
  parameter int DW      = 16,
  parameter int COEF_W  = 20,
  parameter int COEF_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               commit,
  input  reg_sel_e           c_sel,
  input  logic [DW-1:0]      c_data,
  input  logic               start_evt,
  output logic               fir_zero_pre,
  output logic               fir_bypass,
  output logic               fir_even_sym,
  output logic [FDEC_W-1:0]  fir_dec_rate,
  output logic [TAPS_W-1:0]  fir_taps,
  output logic               fir_disable,
  output logic               fir_clr_acc,
  output logic               dec_bypass,
  output logic [HRATE_W-1:0] dec_rate,
  output logic [GRW_W-1:0]   dec_growth,
  output logic [STG_W-1:0]   dec_stages,
  output logic               coef_we,
  output logic [COEF_AW-1:0] coef_addr,
  output logic [COEF_W-1:0]  coef_data
);
  localparam int LO_W = COEF_W - DW;

  function automatic logic [COEF_W-1:0] join_coef(input logic [DW-1:0] hi,
                                                   input logic [DW-1:0] lo);
    return {hi, lo[LO_W-1:0]};
  endfunction

  logic wr_fir, wr_coef, wr_dec1, wr_dec2, dis_set;
  logic [COEF_AW-1:0] ptr;
  logic               half_ok;
  logic [DW-1:0]      hi_hold;

  assign wr_fir  = commit && (c_sel == SEL_FIRCFG);
  assign wr_coef = commit && (c_sel == SEL_COEF);
  assign wr_dec1 = commit && (c_sel == SEL_DEC1);
  assign wr_dec2 = commit && (c_sel == SEL_DEC2);
  assign dis_set = wr_dec1 && c_data[DIS_BIT];

  // fields with a defined reset value
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fir_bypass  <= 1'b0;
      dec_rate    <= '0;
      dec_stages  <= '0;
      fir_disable <= 1'b1;
    end else begin
      if (wr_fir) fir_bypass <= c_data[FBYP_BIT];
      if (wr_dec1) begin
        dec_rate    <= c_data[HRATE_LSB +: HRATE_W];
        fir_disable <= c_data[DIS_BIT];
      end
      if (wr_dec2) dec_stages <= c_data[STG_LSB +: STG_W];
      if (start_evt) fir_disable <= 1'b0;
    end
  end

  // fields that keep their value through reset
  always_ff @(posedge clk) begin
    if (wr_fir) begin
      fir_zero_pre <= c_data[FZP_BIT];
      fir_even_sym <= c_data[FSYM_BIT];
      fir_dec_rate <= c_data[FDEC_LSB +: FDEC_W];
      fir_taps     <= c_data[TAPS_LSB +: TAPS_W];
    end
    if (wr_dec1) begin
      fir_clr_acc <= c_data[CLA_BIT];
      dec_bypass  <= c_data[HBYP_BIT];
    end
    if (wr_dec2) dec_growth <= c_data[GRW_LSB +: GRW_W];
  end

  // coefficient pairing and address pointer
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      half_ok   <= 1'b0;
      hi_hold   <= '0;
      coef_we   <= 1'b0;
      coef_addr <= '0;
      coef_data <= '0;
    end else begin
      coef_we <= 1'b0;
      if (dis_set) begin
        ptr     <= '0;
        half_ok <= 1'b0;
      end else if (wr_coef) begin
        if (!half_ok) begin
          hi_hold <= c_data;
          half_ok <= 1'b1;
        end else begin
          coef_we   <= 1'b1;
          coef_addr <= ptr;
          coef_data <= join_coef(hi_hold, c_data);
          ptr       <= ptr + 1'b1;
          half_ok   <= 1'b0;
        end
      end
    end
  end

  assert_ptr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dis_set |=> (ptr == '0 && !half_ok));
  assert_coef_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    coef_we |=> !coef_we);
  assert_pair_emits_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_coef && half_ok) |=> coef_we);
  assert_start_clears_R12: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !fir_disable);
endmodule

// File: rtl/fcs_start.sv
module fcs_start (
  input  logic clk,
  input  logic rst_n,
  input  logic astart_n,
  input  logic sstart_n,
  output logic casc_n,
  output logic start_evt,
  output logic run
);
  logic a1, a2, a3, s1, s2;
  logic a_fall, s_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a1  <= 1'b1;
      a2  <= 1'b1;
      a3  <= 1'b1;
      s1  <= 1'b1;
      s2  <= 1'b1;
      run <= 1'b0;
    end else begin
      a1  <= astart_n;
      a2  <= a1;
      a3  <= a2;
      s1  <= sstart_n;
      s2  <= s1;
      run <= run | start_evt;
    end
  end

  assign a_fall    = a3 & ~a2;
  assign s_fall    = s2 & ~s1;
  assign start_evt = a_fall | s_fall;
  assign casc_n    = ~a_fall;

  assert_casc_width_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !casc_n |=> casc_n);
  assert_start_sets_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> run);
  assert_run_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> run);
endmodule

// File: rtl/filt_ctrl_start.sv
module filt_ctrl_start
  import fcs_pkg::*;
#(
  parameter int COEF_W  = 20,
  parameter int COEF_AW = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cs_n,
  input  logic               wr_n,
  input  logic [SEL_W-1:0]   addr,
  input  logic [BUS_W-1:0]   wdata,
  input  logic               astart_n,
  input  logic               sstart_n,
  output logic               casc_n,
  output logic               run,
  output logic               fir_zero_pre,
  output logic               fir_bypass,
  output logic               fir_even_sym,
  output logic [FDEC_W-1:0]  fir_dec_rate,
  output logic [TAPS_W-1:0]  fir_taps,
  output logic               fir_disable,
  output logic               fir_clr_acc,
  output logic               dec_bypass,
  output logic [HRATE_W-1:0] dec_rate,
  output logic [GRW_W-1:0]   dec_growth,
  output logic [STG_W-1:0]   dec_stages,
  output logic               coef_we,
  output logic [COEF_AW-1:0] coef_addr,
  output logic [COEF_W-1:0]  coef_data
);
  logic             commit;
  reg_sel_e         c_sel;
  logic [BUS_W-1:0] c_data;
  logic             start_evt;

  fcs_bus #(.DW(BUS_W)) u_bus (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .wdata(wdata), .commit(commit), .c_sel(c_sel), .c_data(c_data)
  );

  fcs_start u_start (
    .clk(clk), .rst_n(rst_n), .astart_n(astart_n), .sstart_n(sstart_n),
    .casc_n(casc_n), .start_evt(start_evt), .run(run)
  );

  fcs_regs #(.DW(BUS_W), .COEF_W(COEF_W), .COEF_AW(COEF_AW)) u_regs (
    .clk(clk), .rst_n(rst_n), .commit(commit), .c_sel(c_sel), .c_data(c_data),
    .start_evt(start_evt),
    .fir_zero_pre(fir_zero_pre), .fir_bypass(fir_bypass),
    .fir_even_sym(fir_even_sym), .fir_dec_rate(fir_dec_rate),
    .fir_taps(fir_taps), .fir_disable(fir_disable), .fir_clr_acc(fir_clr_acc),
    .dec_bypass(dec_bypass), .dec_rate(dec_rate), .dec_growth(dec_growth),
    .dec_stages(dec_stages), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data)
  );
endmodule

// File: tb/filt_ctrl_start_bench.sv
module filt_ctrl_start_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, wr_n = 1'b1;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic        astart_n = 1'b1, sstart_n = 1'b1;
  logic        casc_n, run;
  logic        fir_zero_pre, fir_bypass, fir_even_sym, fir_disable, fir_clr_acc, dec_bypass;
  logic [3:0]  fir_dec_rate;
  logic [8:0]  fir_taps;
  logic [9:0]  dec_rate;
  logic [5:0]  dec_growth;
  logic [2:0]  dec_stages;
  logic        coef_we;
  logic [7:0]  coef_addr;
  logic [19:0] coef_data;

  always #5 clk = ~clk;

  filt_ctrl_start u_filt_ctrl_start (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wr_n(wr_n), .addr(addr), .wdata(wdata),
    .astart_n(astart_n), .sstart_n(sstart_n), .casc_n(casc_n), .run(run),
    .fir_zero_pre(fir_zero_pre), .fir_bypass(fir_bypass), .fir_even_sym(fir_even_sym),
    .fir_dec_rate(fir_dec_rate), .fir_taps(fir_taps), .fir_disable(fir_disable),
    .fir_clr_acc(fir_clr_acc), .dec_bypass(dec_bypass), .dec_rate(dec_rate),
    .dec_growth(dec_growth), .dec_stages(dec_stages), .coef_we(coef_we),
    .coef_addr(coef_addr), .coef_data(coef_data)
  );

  typedef struct packed { logic [7:0] a; logic [19:0] d; } coef_item_t;
  coef_item_t exp_q[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: every coefficient pulse must match the next queued item
  always @(negedge clk) begin
    if (rst_n && coef_we) begin
      if (exp_q.size() == 0) begin
        chk("R6 unexpected coefficient", {4'h0, coef_addr, coef_data}, 32'hFFFFFFFF);
      end else begin
        coef_item_t e;
        e = exp_q.pop_front();
        chk("R5 coefficient value", {12'h0, coef_data}, {12'h0, e.d});
        chk("R6 coefficient address", {24'h0, coef_addr}, {24'h0, e.a});
      end
    end
  end

  task automatic bus_write(input logic [1:0] a, input logic [15:0] d, input logic sel_n);
    @(negedge clk);
    addr = a; wdata = d; cs_n = sel_n; wr_n = 1'b0;
    @(negedge clk);
    wr_n = 1'b1;
    @(negedge clk);
    cs_n = 1'b1;
  endtask

  // driver: two writes plus the expected item for the scoreboard
  task automatic push_coef(input logic [7:0] a, input logic [15:0] hi, input logic [15:0] lo);
    exp_q.push_back({a, hi, lo[3:0]});
    bus_write(2'd1, hi, 1'b0);
    bus_write(2'd1, lo, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  function automatic logic [15:0] fir_word(input logic zp, input logic byp, input logic sym,
                                           input logic [3:0] fd, input logic [8:0] tp);
    return {zp, byp, sym, fd, tp};
  endfunction

  function automatic logic [15:0] dec1_word(input logic dis, input logic cla,
                                            input logic hb, input logic [9:0] rt);
    return {3'b000, dis, cla, hb, rt};
  endfunction

  initial begin
    #2000000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    @(negedge clk);
    // R7 / R11: reset state
    chk("R7 disable after reset", {31'h0, fir_disable}, 32'h1);
    chk("R7 fir bypass after reset", {31'h0, fir_bypass}, 32'h0);
    chk("R7 rate after reset", {22'h0, dec_rate}, 32'h0);
    chk("R7 stages after reset", {29'h0, dec_stages}, 32'h0);
    chk("R11 run after reset", {31'h0, run}, 32'h0);
    chk("R9 cascade idle", {31'h0, casc_n}, 32'h1);
    chk("R5 no coef pulse after reset", {31'h0, coef_we}, 32'h0);

    // R2 two patterns
    bus_write(2'd0, fir_word(1'b1, 1'b0, 1'b1, 4'hA, 9'h1A7), 1'b0);
    chk("R2 pattern A", {16'h0, fir_zero_pre, fir_bypass, fir_even_sym, fir_dec_rate, fir_taps},
        {16'h0, 1'b1, 1'b0, 1'b1, 4'hA, 9'h1A7});
    bus_write(2'd0, fir_word(1'b0, 1'b1, 1'b0, 4'h3, 9'h0FE), 1'b0);
    chk("R2 pattern B", {16'h0, fir_zero_pre, fir_bypass, fir_even_sym, fir_dec_rate, fir_taps},
        {16'h0, 1'b0, 1'b1, 1'b0, 4'h3, 9'h0FE});

    // R3
    bus_write(2'd2, dec1_word(1'b0, 1'b1, 1'b1, 10'h2C5), 1'b0);
    chk("R3 dec1 fields", {19'h0, fir_disable, fir_clr_acc, dec_bypass, dec_rate},
        {19'h0, 1'b0, 1'b1, 1'b1, 10'h2C5});

    // R4
    bus_write(2'd3, {7'h0, 6'h2D, 3'd5}, 1'b0);
    chk("R4 dec2 fields", {23'h0, dec_growth, dec_stages}, {23'h0, 6'h2D, 3'd5});

    // R1: chip select high blocks the write
    bus_write(2'd3, {7'h0, 6'h11, 3'd2}, 1'b1);
    chk("R1 deselected write ignored", {23'h0, dec_growth, dec_stages}, {23'h0, 6'h2D, 3'd5});

    // R5 / R6: three coefficients from address 0
    push_coef(8'd0, 16'hABCD, 16'hFFF3);
    push_coef(8'd1, 16'h1234, 16'h000E);
    push_coef(8'd2, 16'h8001, 16'h5A5A);
    @(negedge clk);
    chk("R6 all coefficients seen", exp_q.size(), 0);

    // R8: disable write rewinds the pointer
    bus_write(2'd2, dec1_word(1'b1, 1'b0, 1'b0, 10'h010), 1'b0);
    chk("R3 disable bit set", {31'h0, fir_disable}, 32'h1);
    push_coef(8'd0, 16'h0F0F, 16'h0007);
    // R8: a lone first half is dropped by disable
    bus_write(2'd1, 16'hDEAD, 1'b0);
    bus_write(2'd2, dec1_word(1'b1, 1'b0, 1'b0, 10'h010), 1'b0);
    push_coef(8'd0, 16'h7777, 16'h0009);
    @(negedge clk);
    chk("R8 pairing restarted", exp_q.size(), 0);

    // R7: reset clears some fields and keeps others
    bus_write(2'd0, fir_word(1'b1, 1'b1, 1'b1, 4'h6, 9'h055), 1'b0);
    bus_write(2'd2, dec1_word(1'b0, 1'b1, 1'b1, 10'h3FF), 1'b0);
    bus_write(2'd3, {7'h0, 6'h22, 3'd4}, 1'b0);
    push_coef(8'd1, 16'h4444, 16'h0001);
    bus_write(2'd1, 16'hBEEF, 1'b0);
    do_reset();
    @(negedge clk);
    chk("R7 cleared fields", {14'h0, fir_bypass, fir_disable, dec_rate, 3'b000, dec_stages},
        {14'h0, 1'b0, 1'b1, 10'h0, 3'b000, 3'd0});
    chk("R7 kept fir fields", {16'h0, fir_zero_pre, fir_even_sym, fir_dec_rate, fir_taps},
        {16'h0, 1'b1, 1'b1, 4'h6, 9'h055});
    chk("R7 kept dec fields", {24'h0, fir_clr_acc, dec_bypass, dec_growth},
        {24'h0, 1'b1, 1'b1, 6'h22});
    push_coef(8'd0, 16'h2468, 16'h000C);
    @(negedge clk);
    chk("R7 pointer rewound", exp_q.size(), 0);

    // R11: no start, no run
    repeat (5) @(negedge clk);
    chk("R11 idle without start", {31'h0, run}, 32'h0);

    // R9 asynchronous start timing
    astart_n = 1'b0;
    @(negedge clk);
    chk("R9 after first edge", {30'h0, casc_n, run}, {30'h0, 1'b1, 1'b0});
    @(negedge clk);
    chk("R9 cascade low after second edge", {30'h0, casc_n, run}, {30'h0, 1'b0, 1'b0});
    @(negedge clk);
    chk("R9 run after third edge", {30'h0, casc_n, run}, {30'h0, 1'b1, 1'b1});
    chk("R12 async start clears disable", {31'h0, fir_disable}, 32'h0);
    astart_n = 1'b1;
    repeat (6) @(negedge clk);
    chk("R11 run stays set", {31'h0, run}, 32'h1);
    chk("R9 single cascade pulse", {31'h0, casc_n}, 32'h1);

    // R10 synchronous start
    do_reset();
    @(negedge clk);
    chk("R11 reset stops run", {31'h0, run}, 32'h0);
    sstart_n = 1'b0;
    @(negedge clk);
    chk("R10 after first edge", {31'h0, run}, 32'h0);
    @(negedge clk);
    chk("R10 run after second edge", {31'h0, run}, 32'h1);
    chk("R12 sync start clears disable", {31'h0, fir_disable}, 32'h0);
    chk("R9 sync start leaves cascade high", {31'h0, casc_n}, 32'h1);
    sstart_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R11 run held after sync start", {31'h0, run}, 32'h1);

    finish_run();
  end
endmodule